// File: doc/BRIEF.md
# Ethernet Receive Payload Framer

This block sits behind an Ethernet PHY receive port and turns the raw stream into payload words for a command parser. It hunts for the preamble and start delimiter, then swallows the MAC header while it picks up the header's length field. The payload bytes that follow are packed into 32-bit words. Each word leaves with a valid strobe, a first-word marker and a last-word marker. A single error pulse tells the consumer that the frame just closed cannot be trusted.

The input is 8 bits wide. A mode input selects byte lanes for gigabit links or nibble lanes for 100 Mb/s links, where only the low four bits carry data. A frame is the unbroken run of cycles with the input valid high. The first cycle with valid low closes the frame. A gap before the advertised number of payload bytes has arrived is therefore a truncation and an error. Payload beyond the advertised length is thrown away, and that too is an error. The mode input is expected to change only between frames.

Top module: `erx_payload_framer`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof and frame_err are low and out_data is zero.
- R2: With gig_mode high, every valid cycle delivers one byte from rx_data[7:0]. With gig_mode low, two valid cycles make one byte: rx_data[3:0] of the first cycle is the byte's low nibble and rx_data[3:0] of the second cycle is its high nibble.
- R3: A frame starts after one or more 0x55 bytes followed by 0xD5. Any other byte seen before 0xD5 abandons the hunt, and the hunt restarts at the next 0x55.
- R4: The 14 bytes after 0xD5 are the MAC header and are never forwarded. Header bytes 12 and 13 (counting from 0) hold the payload length in bytes, high byte first.
- R5: Payload bytes are packed in arrival order, the first byte of each word in out_data[31:24] and the fourth in out_data[7:0]. Each word is presented for one cycle with out_valid high.
- R6: out_sof is high on the first word of a frame and out_eof on its last. When the length is not a multiple of 4, the unused low bytes of the last word are zero.
- R7: If valid drops during the payload before the advertised length has arrived, the bytes held so far are sent as a zero-padded word with out_eof (an all-zero word if none are held), and frame_err pulses in that same cycle.
- R8: If valid drops while the header is still arriving, frame_err pulses and no word is sent.
- R9: Bytes that arrive after the advertised length has been sent produce no word, and frame_err pulses when the frame closes.
- R10: If rx_err is high in any valid cycle from the start delimiter to the end of the frame, the words are still forwarded and frame_err pulses when the frame closes.
- R11: frame_err is a single-cycle pulse and stays low for a frame with a matching length and no rx_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gig_mode | input | 1 | 1: byte lanes, 0: nibble lanes on rx_data[3:0] |
| rx_valid | input | 1 | PHY data valid |
| rx_err | input | 1 | PHY receive error |
| rx_data | input | 8 | PHY receive data |
| out_data | output | 32 | Payload word, first byte in the top bits |
| out_valid | output | 1 | out_data carries a payload word this cycle |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| frame_err | output | 1 | One-cycle pulse: the frame just closed is bad |

## Verification
On every cycle the assertions check the word-level framing: markers never appear without a valid word, the first word after a last word carries the start marker, the error output never lasts more than one cycle, and in nibble mode no two bytes are assembled in consecutive cycles. Whether the packed bytes are correct and in the right order, whether the header is really dropped and the length honoured, and whether truncation, overrun and PHY errors give exactly one error pulse at the right word can only be shown by the bench's frames. The bench sweeps payload lengths across several word-alignment cases in both lane modes and compares each word with values computed from the byte index.

// File: rtl/erx_pkg.sv
package erx_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LEN_W    = 16;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_HDR   = 3'd2,
    ST_PAY   = 3'd3,
    ST_DRAIN = 3'd4
  } frm_state_t;
endpackage

// File: rtl/erx_lane_unpack.sv
module erx_lane_unpack (
  input  logic       clk,
  input  logic       rst,
  input  logic       gig_mode,
  input  logic       rx_valid,
  input  logic       rx_err,
  input  logic [7:0] rx_data,
  output logic       b_stb,
  output logic [7:0] b_data,
  output logic       b_err,
  output logic       b_gap
);
  logic       phase_q;
  logic [3:0] lo_nib_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_stb    <= 1'b0;
      b_data   <= '0;
      b_err    <= 1'b0;
      b_gap    <= 1'b0;
      phase_q  <= 1'b0;
      lo_nib_q <= '0;
    end else begin
      b_err <= rx_valid & rx_err;
      b_gap <= ~rx_valid;
      b_stb <= 1'b0;
      if (!rx_valid) begin
        phase_q <= 1'b0;
      end else if (gig_mode) begin
        phase_q <= 1'b0;
        b_stb   <= 1'b1;
        b_data  <= rx_data;
      end else if (!phase_q) begin
        phase_q  <= 1'b1;
        lo_nib_q <= rx_data[3:0];
      end else begin
        phase_q <= 1'b0;
        b_stb   <= 1'b1;
        b_data  <= {rx_data[3:0], lo_nib_q};
      end
    end
  end

  // nibble lanes need two valid cycles per byte
  AST_NIB_SPACING: assert property (@(posedge clk) disable iff (rst)
    (b_stb && !gig_mode) |=> !(b_stb && !gig_mode)); // R2
endmodule

// File: rtl/erx_frame_parse.sv
module erx_frame_parse
  import erx_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 14,
  parameter int unsigned LEN_OFS   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_stb,
  input  logic [7:0] in_byte,
  input  logic       in_err,
  input  logic       in_gap,
  output logic       pk_start,
  output logic       pk_push,
  output logic [7:0] pk_byte,
  output logic       pk_last,
  output logic       pk_flush,
  output logic       frame_err
);
  localparam int unsigned HC_W = $clog2(HDR_BYTES);
  localparam logic [HC_W-1:0] LEN_HI   = HC_W'(LEN_OFS);
  localparam logic [HC_W-1:0] LEN_LO   = HC_W'(LEN_OFS + 1);
  localparam logic [HC_W-1:0] HDR_LAST = HC_W'(HDR_BYTES - 1);

  frm_state_t       st_q, st_d;
  logic [HC_W-1:0]  hcnt_q, hcnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] pcnt_q, pcnt_d;
  logic             bad_q, bad_d;
  logic             err_d;

  always_comb begin
    st_d     = st_q;
    hcnt_d   = hcnt_q;
    len_d    = len_q;
    pcnt_d   = pcnt_q;
    bad_d    = bad_q;
    err_d    = 1'b0;
    pk_start = 1'b0;
    pk_push  = 1'b0;
    pk_last  = 1'b0;
    pk_flush = 1'b0;
    pk_byte  = in_byte;
    unique case (st_q)
      ST_IDLE: begin
        if (in_stb && in_byte == PRE_BYTE) st_d = ST_PRE;
      end
      ST_PRE: begin
        if (in_gap) begin
          st_d = ST_IDLE;
        end else if (in_stb) begin
          if (in_byte == SFD_BYTE) begin
            st_d   = ST_HDR;
            hcnt_d = '0;
            bad_d  = in_err;
          end else if (in_byte != PRE_BYTE) begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_HDR: begin
        if (in_err) bad_d = 1'b1;
        if (in_gap) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end else if (in_stb) begin
          hcnt_d = hcnt_q + 1'b1;
          if (hcnt_q == LEN_HI) len_d[15:8] = in_byte;
          if (hcnt_q == LEN_LO) len_d[7:0]  = in_byte;
          if (hcnt_q == HDR_LAST) begin
            pcnt_d   = '0;
            pk_start = 1'b1;
            st_d     = (len_d == '0) ? ST_DRAIN : ST_PAY;
          end
        end
      end
      ST_PAY: begin
        if (in_err) bad_d = 1'b1;
        if (in_gap) begin
          pk_flush = 1'b1;
          err_d    = 1'b1;
          st_d     = ST_IDLE;
        end else if (in_stb) begin
          pk_push = 1'b1;
          pcnt_d  = pcnt_q + 1'b1;
          if (pcnt_d == len_q) begin
            pk_last = 1'b1;
            st_d    = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (in_stb || in_err) bad_d = 1'b1;
        if (in_gap) begin
          err_d = bad_q;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      hcnt_q    <= '0;
      len_q     <= '0;
      pcnt_q    <= '0;
      bad_q     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      st_q      <= st_d;
      hcnt_q    <= hcnt_d;
      len_q     <= len_d;
      pcnt_q    <= pcnt_d;
      bad_q     <= bad_d;
      frame_err <= err_d;
    end
  end

  AST_PAY_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAY) |-> (pcnt_q < len_q)); // R9
  AST_PUSH_NOT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !(pk_push && pk_flush)); // R7
endmodule

// File: rtl/erx_word_pack.sv
module erx_word_pack #(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pk_start,
  input  logic                    pk_push,
  input  logic [7:0]              pk_byte,
  input  logic                    pk_last,
  input  logic                    pk_flush,
  output logic [WORD_BYTES*8-1:0] o_data,
  output logic                    o_valid,
  output logic                    o_sof,
  output logic                    o_eof
);
  localparam int unsigned DATA_W = WORD_BYTES * 8;
  localparam int unsigned CNT_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WORD_BYTES - 1);

  logic [DATA_W-1:0] acc_q, acc_ins;
  logic [CNT_W-1:0]  cnt_q;
  logic              sof_pend_q;

  always_comb begin
    acc_ins = acc_q;
    for (int i = 0; i < int'(WORD_BYTES); i++) begin
      if (i == int'(WORD_BYTES) - 1 - int'(cnt_q)) acc_ins[i*8 +: 8] = pk_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      sof_pend_q <= 1'b0;
      o_data     <= '0;
      o_valid    <= 1'b0;
      o_sof      <= 1'b0;
      o_eof      <= 1'b0;
    end else begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_eof   <= 1'b0;
      if (pk_start) begin
        acc_q      <= '0;
        cnt_q      <= '0;
        sof_pend_q <= 1'b1;
      end else if (pk_push) begin
        if (cnt_q == CNT_TOP || pk_last) begin
          o_data     <= acc_ins;
          o_valid    <= 1'b1;
          o_sof      <= sof_pend_q;
          o_eof      <= pk_last;
          sof_pend_q <= 1'b0;
          acc_q      <= '0;
          cnt_q      <= '0;
        end else begin
          acc_q <= acc_ins;
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (pk_flush) begin
        o_data     <= acc_q;
        o_valid    <= 1'b1;
        o_sof      <= sof_pend_q;
        o_eof      <= 1'b1;
        sof_pend_q <= 1'b0;
        acc_q      <= '0;
        cnt_q      <= '0;
      end
    end
  end

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    o_sof |-> o_valid); // R6
  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    o_eof |-> o_valid); // R6
endmodule

// File: rtl/erx_payload_framer.sv
module erx_payload_framer #(
  parameter int unsigned HDR_BYTES  = 14,
  parameter int unsigned LEN_OFS    = 12,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    gig_mode,
  input  logic                    rx_valid,
  input  logic                    rx_err,
  input  logic [7:0]              rx_data,
  output logic [WORD_BYTES*8-1:0] out_data,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic                    out_eof,
  output logic                    frame_err
);
  logic       b_stb, b_err, b_gap;
  logic [7:0] b_data;
  logic       pk_start, pk_push, pk_last, pk_flush;
  logic [7:0] pk_byte;

  erx_lane_unpack u_unpack (
    .clk(clk), .rst(rst), .gig_mode(gig_mode),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_data(rx_data),
    .b_stb(b_stb), .b_data(b_data), .b_err(b_err), .b_gap(b_gap)
  );

  erx_frame_parse #(.HDR_BYTES(HDR_BYTES), .LEN_OFS(LEN_OFS)) u_parse (
    .clk(clk), .rst(rst),
    .in_stb(b_stb), .in_byte(b_data), .in_err(b_err), .in_gap(b_gap),
    .pk_start(pk_start), .pk_push(pk_push), .pk_byte(pk_byte),
    .pk_last(pk_last), .pk_flush(pk_flush), .frame_err(frame_err)
  );

  erx_word_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst(rst),
    .pk_start(pk_start), .pk_push(pk_push), .pk_byte(pk_byte),
    .pk_last(pk_last), .pk_flush(pk_flush),
    .o_data(out_data), .o_valid(out_valid), .o_sof(out_sof), .o_eof(out_eof)
  );

  // after a last word, the next word must open a frame
  logic want_sof_q;
  always_ff @(posedge clk) begin
    if (rst)                       want_sof_q <= 1'b1;
    else if (out_valid && out_eof) want_sof_q <= 1'b1;
    else if (out_valid)            want_sof_q <= 1'b0;
  end

  AST_SOF_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    (out_valid && want_sof_q) |-> out_sof); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err); // R11
endmodule

// File: tb/test_erx_payload_framer.sv
module test_erx_payload_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_W = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gig_mode = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [31:0] out_data;
  logic        out_valid, out_sof, out_eof, frame_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] cap_data [MAX_W];
  logic        cap_sof  [MAX_W];
  logic        cap_eof  [MAX_W];
  logic        cap_err  [MAX_W];
  int          cap_n = 0;
  int          err_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erx_payload_framer i_erx_payload_framer (
    .clk(clk), .rst(rst), .gig_mode(gig_mode),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_data(rx_data),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (out_valid && cap_n < MAX_W) begin
        cap_data[cap_n] = out_data;
        cap_sof[cap_n]  = out_sof;
        cap_eof[cap_n]  = out_eof;
        cap_err[cap_n]  = frame_err;
        cap_n++;
      end
      if (frame_err) err_n++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(input int idx, input int seed);
    return 8'((idx * 29 + seed * 7 + 3) & 255);
  endfunction

  task automatic put_byte(input logic [7:0] b, input logic e);
    if (gig_mode) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_err = e;
    end else begin
      @(negedge clk); rx_valid = 1'b1; rx_data = {4'hA, b[3:0]}; rx_err = e;
      @(negedge clk); rx_valid = 1'b1; rx_data = {4'h5, b[7:4]}; rx_err = e;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b0; rx_err = 1'b0; rx_data = 8'hEE;
    end
  endtask

  // hdr_cut >= 0 ends the frame after that many header bytes
  task automatic send_frame(input bit gig, input int npre, input int lenf, input int nsent,
                            input int err_at, input bit junk, input int hdr_cut, input int seed);
    idle(2);
    gig_mode = gig;
    cap_n = 0;
    err_n = 0;
    if (junk) begin
      put_byte(8'h55, 1'b0); put_byte(8'h12, 1'b0); put_byte(8'hD5, 1'b0);
    end
    for (int i = 0; i < npre; i++) put_byte(8'h55, 1'b0);
    put_byte(8'hD5, 1'b0);
    for (int i = 0; i < 14; i++) begin
      if (hdr_cut >= 0 && i >= hdr_cut) break;
      if (i == 12)      put_byte(8'(lenf >> 8), 1'b0);
      else if (i == 13) put_byte(8'(lenf), 1'b0);
      else              put_byte(8'h55, 1'b0);
    end
    if (hdr_cut < 0)
      for (int i = 0; i < nsent; i++) put_byte(pay_byte(i, seed), (i == err_at) ? 1'b1 : 1'b0);
    idle(8);
  endtask

  task automatic expect_frame(input string req, input int lenf, input int nsent, input int seed,
                              input bit bad);
    int eff, nw;
    bit short_f;
    short_f = (nsent < lenf);
    eff = short_f ? nsent : lenf;
    if (short_f) nw = (nsent % 4 != 0) ? (nsent + 3) / 4 : nsent / 4 + 1;
    else         nw = (lenf + 3) / 4;
    check(cap_n == nw, {req, " word count"}, 32'(cap_n), 32'(nw));
    for (int k = 0; k < nw && k < cap_n; k++) begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < 4; j++)
        if (4*k + j < eff) w[31-8*j -: 8] = pay_byte(4*k + j, seed);
      check(cap_data[k] === w, {req, " word data (R5)"}, cap_data[k], w);
      check(cap_sof[k] === (k == 0), {req, " sof (R6)"}, 32'(cap_sof[k]), 32'(k == 0));
      check(cap_eof[k] === (k == nw-1), {req, " eof (R6)"}, 32'(cap_eof[k]), 32'(k == nw-1));
      if (short_f && k == nw-1)
        check(cap_err[k] === 1'b1, {req, " error with eof word (R7)"}, 32'(cap_err[k]), 32'd1);
    end
    check(err_n == (bad ? 1 : 0), {req, " error pulses (R11)"}, 32'(err_n), bad ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0 && out_sof === 1'b0 && out_eof === 1'b0 && frame_err === 1'b0,
          "R1 reset strobes", {28'd0, out_valid, out_sof, out_eof, frame_err}, 32'd0);
    check(out_data === 32'd0, "R1 reset data", out_data, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2 R5 R6 byte lanes, every word alignment
    for (int n = 1; n <= 9; n++) begin
      send_frame(1'b1, 7, n, n, -1, 1'b0, -1, n);
      expect_frame("R2 gig lanes", n, n, n, 1'b0);
    end
    // R2 nibble lanes
    for (int n = 1; n <= 6; n++) begin
      send_frame(1'b0, 7, n, n, -1, 1'b0, -1, n + 20);
      expect_frame("R2 nibble lanes", n, n, n + 20, 1'b0);
    end
    // R3 aborted hunt before a real preamble, single 0x55 preamble
    send_frame(1'b1, 1, 5, 5, -1, 1'b1, -1, 3);
    expect_frame("R3 hunt restart", 5, 5, 3, 1'b0);
    // R4 header length above 255 bytes
    send_frame(1'b1, 3, 260, 260, -1, 1'b0, -1, 4);
    check(cap_n == 65 || cap_n == MAX_W, "R4 long length word count", 32'(cap_n), 32'd65);
    check(cap_data[0] === {pay_byte(0,4), pay_byte(1,4), pay_byte(2,4), pay_byte(3,4)},
          "R4 header dropped", cap_data[0], {pay_byte(0,4), pay_byte(1,4), pay_byte(2,4), pay_byte(3,4)});
    check(err_n == 0, "R4 long frame no error", 32'(err_n), 32'd0);
    // R7 truncated payload: mid-word, on a word boundary, no payload at all
    for (int s = 0; s <= 6; s++) begin
      send_frame(s[0], 5, 8, s, -1, 1'b0, -1, 9 + s);
      expect_frame("R7 truncated", 8, s, 9 + s, 1'b1);
    end
    // R8 cut inside the header
    for (int h = 0; h < 14; h += 5) begin
      send_frame(1'b1, 5, 6, 6, -1, 1'b0, h, 2);
      check(cap_n == 0, "R8 header cut no words", 32'(cap_n), 32'd0);
      check(err_n == 1, "R8 header cut error", 32'(err_n), 32'd1);
    end
    // R9 overlong payload
    send_frame(1'b1, 5, 3, 7, -1, 1'b0, -1, 11);
    expect_frame("R9 overlong gig", 3, 7, 11, 1'b1);
    send_frame(1'b0, 5, 4, 6, -1, 1'b0, -1, 12);
    expect_frame("R9 overlong nibble", 4, 6, 12, 1'b1);
    // R10 PHY error inside payload
    send_frame(1'b1, 5, 6, 6, 2, 1'b0, -1, 13);
    expect_frame("R10 rx_err gig", 6, 6, 13, 1'b1);
    send_frame(1'b0, 5, 5, 5, 4, 1'b0, -1, 14);
    expect_frame("R10 rx_err nibble", 5, 5, 14, 1'b1);
    // R11 clean frame after errors
    send_frame(1'b1, 5, 4, 4, -1, 1'b0, -1, 15);
    expect_frame("R11 clean after bad", 4, 4, 15, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule